// File: doc/BRIEF.md
# Early-Terminating Sequential Shift-Add Multiplier

This block multiplies two unsigned N-bit operands into a 2N-bit product, one partial-product step per clock. A request is accepted when `start` is high while `ready` is high. The block then clears its accumulator and loads the multiplicand into a 2N-bit shift register and the multiplier into an N-bit shift register. On every step, the multiplicand is added to the accumulator when bit 0 of the multiplier is one. Both operand registers then move one place: the multiplicand to the left and the multiplier to the right, with zeros shifted in.

The loop does not run a fixed count of N steps. It stops in the step after which the remaining multiplier is zero. A small multiplier such as 3 therefore finishes after two steps, and a zero multiplier finishes after one. When the block finishes it drives `done` high for one cycle. At the same edge it registers the product and the number of steps used. Both values hold until the next operation completes.

Top module: `shift_add_mul`

## Requirements
- R1: After reset, `ready` is 1, `done` is 0, `product` is 0 and `cycles` is 0.
- R2: `start` is accepted only at a clock edge where `ready` is 1. In the cycle after that edge, `ready` is 0.
- R3: `product` equals the full unsigned product of `a` and `b` as sampled at the accepted edge, with no bits lost (for example, 7 times 5 gives 35, binary 100011).
- R4: For a nonzero multiplier, `cycles` equals the index of the multiplier's highest set bit plus one. Its value is therefore between 1 and N.
- R5: `done` is high in the k-th cycle after the cycle in which the start edge occurred, where k is the value reported on `cycles`.
- R6: A multiplier of zero takes exactly one step. It yields a product of 0 and a `cycles` value of 1.
- R7: `done` is high for exactly one cycle per operation, and `ready` is 1 in that cycle.
- R8: A `start` that arrives while `ready` is 0 is ignored: the running operation's product and step count are unchanged, and no extra operation follows.
- R9: `product` and `cycles` keep their values from one `done` pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a multiply; taken only while ready is 1 |
| a | input | WIDTH | Multiplicand, unsigned |
| b | input | WIDTH | Multiplier, unsigned |
| ready | output | 1 | Block idle and able to accept start |
| product | output | 2*WIDTH | Registered product of the last operation |
| done | output | 1 | One-cycle pulse when product and cycles update |
| cycles | output | $clog2(WIDTH+1) | Steps used by the last operation |

## Verification
The start edge loads the operands. Each later edge performs one step, and the step that leaves the multiplier empty also registers `product`, `cycles` and `done`. The results are therefore visible k cycles after the start cycle, where k is one more than the highest set-bit index of `b` (or 1 when `b` is zero). The bench drives and samples on falling edges. It counts falling edges from the start cycle to the first `done`, compares that count with k computed from `b`, and reads `product` and `cycles` in the same sample. One falling edge later it checks that `done` has dropped and the results have held. In some operations the bench pulses `start` with different operands in the first busy cycle, so that a start that leaked through would show up as a wrong result or as extra `done` pulses.

// File: rtl/shift_add_mul_pkg.sv
package shift_add_mul_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mul_state_e;

endpackage

// File: rtl/shift_add_mul_dp.sv
// Operand shift registers and accumulator for the shift-add loop.
module shift_add_mul_dp #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic [2*WIDTH-1:0] acc_sum,
  output logic               last
);

  localparam int PW = 2 * WIDTH;

  logic [PW-1:0]    mcand_q, mcand_d;
  logic [WIDTH-1:0] mplier_q, mplier_d;
  logic [PW-1:0]    acc_q, acc_d;
  logic [PW-1:0]    addend;
  logic             reg_en;

  assign addend  = mplier_q[0] ? mcand_q : '0;
  assign acc_sum = acc_q + addend;
  assign last    = (mplier_q[WIDTH-1:1] == '0);
  assign reg_en  = load | step;

  always_comb begin
    mcand_d  = mcand_q;
    mplier_d = mplier_q;
    acc_d    = acc_q;
    if (load) begin
      mcand_d  = {{WIDTH{1'b0}}, a};
      mplier_d = b;
      acc_d    = '0;
    end else if (step) begin
      mcand_d  = {mcand_q[PW-2:0], 1'b0};
      mplier_d = {1'b0, mplier_q[WIDTH-1:1]};
      acc_d    = acc_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
    end else if (reg_en) begin
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
      acc_q    <= acc_d;
    end
  end

  AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (acc_q >= $past(acc_q))); // R3

endmodule

// File: rtl/shift_add_mul_ctrl.sv
// Sequencer: accepts requests, counts steps, registers results.
module shift_add_mul_ctrl
  import shift_add_mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       last,
  input  logic [2*WIDTH-1:0]         acc_sum,
  output logic                       load,
  output logic                       step,
  output logic                       ready,
  output logic                       done,
  output logic [2*WIDTH-1:0]         product,
  output logic [$clog2(WIDTH+1)-1:0] cycles
);

  localparam int CW = $clog2(WIDTH + 1);

  mul_state_e           state_q, state_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic                 finish;
  logic                 done_d;
  logic [2*WIDTH-1:0]   product_q;
  logic [CW-1:0]        cycles_q;

  assign ready  = (state_q == ST_IDLE);
  assign load   = ready & start;
  assign step   = (state_q == ST_RUN);
  assign finish = step & last;
  assign done_d = finish;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (load) begin
      state_d = ST_RUN;
      cnt_d   = '0;
    end else if (step) begin
      cnt_d = cnt_q + CW'(1);
      if (last) state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done    <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      product_q <= '0;
      cycles_q  <= '0;
    end else if (finish) begin
      product_q <= acc_sum;
      cycles_q  <= cnt_q + CW'(1);
    end
  end

  assign product = product_q;
  assign cycles  = cycles_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready); // R7
  AST_CYCLES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cycles >= CW'(1) && cycles <= CW'(WIDTH))); // R4
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((product != $past(product)) || (cycles != $past(cycles))) |-> done); // R9

endmodule

// File: rtl/shift_add_mul.sv
// Top: early-terminating unsigned shift-add multiplier.
module shift_add_mul #(
  parameter int WIDTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [WIDTH-1:0]           a,
  input  logic [WIDTH-1:0]           b,
  output logic                       ready,
  output logic [2*WIDTH-1:0]         product,
  output logic                       done,
  output logic [$clog2(WIDTH+1)-1:0] cycles
);

  logic               load;
  logic               step;
  logic               last;
  logic [2*WIDTH-1:0] acc_sum;

  shift_add_mul_dp #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (step),
    .a       (a),
    .b       (b),
    .acc_sum (acc_sum),
    .last    (last)
  );

  shift_add_mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .last    (last),
    .acc_sum (acc_sum),
    .load    (load),
    .step    (step),
    .ready   (ready),
    .done    (done),
    .product (product),
    .cycles  (cycles)
  );

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> !ready); // R2
  AST_ZERO_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready && (b == '0)) |=> ##1 done); // R6
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ready) |=> (!ready || done)); // R8

endmodule

// File: tb/tb_shift_add_mul.sv
module tb_shift_add_mul;

  localparam int W  = 5;
  localparam int PW = 2 * W;
  localparam int CW = $clog2(W + 1);

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [W-1:0]  a;
  logic [W-1:0]  b;
  logic          ready;
  logic [PW-1:0] product;
  logic          done;
  logic [CW-1:0] cycles;

  int compared;
  int mismatched;
  int tick;

  shift_add_mul #(.WIDTH(W)) dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .a       (a),
    .b       (b),
    .ready   (ready),
    .product (product),
    .done    (done),
    .cycles  (cycles)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    tick <= tick + 1;
    if (tick > 150000) begin
      mismatched = mismatched + 1;
      $display("FAIL watchdog: run hung, actual tick %0d expected below 150000", tick);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    compared = compared + 1;
    if (act != exp) begin
      mismatched = mismatched + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int steps_for(input int mval);
    int s;
    s = 1;
    for (int i = 0; i < W; i++) if (mval[i]) s = i + 1;
    return s;
  endfunction

  task automatic run_op(input int av, input int bv, input bit poke);
    int lat;
    int k;
    int pulses;
    k = steps_for(bv);
    @(negedge clk);
    a = W'(av);
    b = W'(bv);
    start = 1'b1;
    @(negedge clk);
    check("R2 ready low after accept", ready, 0);
    if (poke) begin
      start = 1'b1;
      a = W'(av ^ 5'h15);
      b = W'(bv ^ 5'h1B);
    end else begin
      start = 1'b0;
    end
    lat = 0;
    while (!done && lat <= W + 2) begin
      @(negedge clk);
      start = 1'b0;
      lat = lat + 1;
    end
    check("R5 latency to done", lat, k);
    check("R3 product", product, av * bv);
    if (bv == 0) begin
      check("R6 zero multiplier product", product, 0);
      check("R6 zero multiplier steps", cycles, 1);
    end else begin
      check("R4 step count", cycles, k);
    end
    check("R7 ready with done", ready, 1);
    @(negedge clk);
    check("R7 done single pulse", done, 0);
    check("R9 product held", product, av * bv);
    if (poke) begin
      pulses = 0;
      for (int j = 0; j < W + 2; j++) begin
        @(negedge clk);
        if (done) pulses = pulses + 1;
      end
      check("R8 no extra operation from busy start", pulses, 0);
      check("R8 product unchanged", product, av * bv);
      check("R8 steps unchanged", cycles, k);
    end
  endtask

  initial begin
    compared   = 0;
    mismatched = 0;
    tick       = 0;
    start      = 1'b0;
    a          = '0;
    b          = '0;
    rst_n      = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset ready", ready, 1);
    check("R1 reset done", done, 0);
    check("R1 reset product", product, 0);
    check("R1 reset cycles", cycles, 0);
    rst_n = 1'b1;

    run_op(7, 5, 1'b0);
    check("R3 seven times five", product, 35);
    run_op(31, 31, 1'b0);
    run_op(9, 3, 1'b0);
    check("R4 small multiplier steps", cycles, 2);
    run_op(0, 0, 1'b0);

    for (int x = 0; x < (1 << W); x++) begin
      for (int y = 0; y < (1 << W); y++) begin
        run_op(x, y, ((x + y) % 7) == 0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule